// File: doc/BRIEF.md
# CPU I/O Port and Interrupt Controller

This block is a small set of byte-wide peripheral registers placed in the I/O space of a Z80-style processor. It recognises four consecutive port addresses in the low address byte, from a base of 80H up to 83H. A bus cycle counts as an I/O access only when the I/O request strobe is low and the opcode-fetch strobe is high. The tristate data bus is modelled as a separate input byte, an output byte and an output-enable.

Behind the four ports sit the following:

- an interrupt mask, one enable bit per external source;
- a live status byte showing the cassette input and the six interrupt sources;
- a control bit for the floppy-drive reset line;
- two byte-wide output registers for motor phases and relays. Their pins are driven active low.

An open-drain interrupt request is pulled low while any source is high and its enable bit is set.

Writes take effect on the rising edge of the write strobe, sampled on the system clock. The floppy reset is forced active by the chip reset and stays active until software writes a 1 to its control bit.

Top module: `io_port_irq_ctrl`

## Requirements
- R1: A write or read counts only when `iorq_n` is 0, `m1_n` is 1 and `addr` is 80H–83H. A write made with `m1_n` low, or to any other address, leaves every register unchanged.
- R2: A write commits on the write-strobe rising edge. Its effect shows after the first clock edge at which `wr_n` is sampled high following one or more low samples. The data and address used are those of the last low sample. While `wr_n` stays low, outputs keep their old values.
- R3: Writing 80H stores all 8 bits of the interrupt-enable mask, and reading 80H returns them. Bit i enables source i: 0 carriage-return, 1 printer switch, 2 floppy interrupt, 3 CC key, 4 PF key, 5 reverse.
- R4: Reading 81H returns the live input byte {0, rev_in, pf_key, cc_key, fdc_int, prn_sw, prn_cr, cas_in}, with `cas_in` in bit 0.
- R5: Writing 81H with bit 0 equal to 0 drives `fdd_rst_n` low, and writing bit 0 equal to 1 drives it high. Bits 7..1 of that write have no effect.
- R6: Chip reset (synchronous, `rst_n` low) clears the mask and both output registers and activates the floppy reset. This gives `pb_n`=FFH, `pc_n`=FFH, `fdd_rst_n`=0 and `irq_oe`=0.
- R7: Writing 82H loads a register whose inverse appears on `pb_n`. Reading 82H returns the written value.
- R8: Writing 83H loads a register whose inverse appears on `pc_n`. Reading 83H returns the written value.
- R9: `irq_oe` is 1 and `irq_n` is 0 exactly when some source i is high and mask bit i is 1. Otherwise `irq_oe` is 0 and `irq_n` is 1. The interrupt follows the inputs with no clock delay.
- R10: `dout_oe` is 1 only during a decoded read: the R1 conditions hold and `rd_n` is 0. When `dout_oe` is 0, `dout` is 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous chip reset, active low |
| addr | input | 8 | Low address byte |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | CPU data toward the block |
| dout | output | 8 | Read data toward the CPU |
| dout_oe | output | 1 | Drive enable for `dout` |
| cas_in | input | 1 | Cassette data input |
| prn_cr | input | 1 | Printer carriage-return source |
| prn_sw | input | 1 | Printer switch source |
| fdc_int | input | 1 | Floppy controller interrupt source |
| cc_key | input | 1 | CC key source |
| pf_key | input | 1 | PF key source |
| rev_in | input | 1 | Reverse input source |
| pb_n | output | 8 | Relay and Z-motor pins, active low |
| pc_n | output | 8 | X/Y-motor phase pins, active low |
| fdd_rst_n | output | 1 | Floppy drive reset, active low |
| irq_n | output | 1 | Interrupt request level, low when asserted |
| irq_oe | output | 1 | Open-drain pull-down enable for the interrupt |

## Verification
A wrong internal register value shows at the ports at once. The pins driven from it (`pb_n`, `pc_n`, `fdd_rst_n`, or the interrupt pair through the mask) differ in the cycle after the commit edge. The bench compares every output against its model on every clock, so a bad commit, a missed write or a lost reset is caught within one cycle of its cause. A latch of the wrong address or data byte is a different case: it stays hidden until the write strobe rises. From then it appears as a mismatch on the addressed pins, or on the next readback of that port.

// File: rtl/io_port_pkg.sv
// Package: shared sizes and the port-select encoding of the I/O register block.
// Assumes the four ports occupy an address range aligned to four.
package io_port_pkg;

    localparam int DATA_W = 8;   // CPU data width
    localparam int N_SRC  = 6;   // number of maskable interrupt sources

    // Offset of each port above the base address; the decoder relies on this order.
    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,  // interrupt-enable mask
        SEL_STAT = 2'd1,  // live status read / floppy reset write
        SEL_PB   = 2'd2,  // relay / Z-motor output register
        SEL_PC   = 2'd3   // X/Y-motor output register
    } port_sel_e;

    localparam int FDD_CTRL_BIT = 0;  // data bit that controls the floppy reset

endpackage

// File: rtl/io_bus_decode.sv
// Module: io_bus_decode
// Decodes the four ports from the CPU strobes, produces one-hot read selects,
// and turns a write-strobe rising edge into a single-cycle commit pulse carrying
// the address and data of the last sampled low cycle.
// Assumes the bus strobes are already synchronous to clk.
module io_bus_decode
    import io_port_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80,
    parameter int              D_W       = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [D_W-1:0]    din,
    input  logic              iorq_n,
    input  logic              m1_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [3:0]        rd_sel,
    output logic              wr_commit,
    output port_sel_e         wr_sel,
    output logic [D_W-1:0]    wr_data
);

    localparam int N_PORT = 4;

    logic      hit;
    logic      io_cyc;
    logic      wr_now;
    logic      rd_now;
    logic      wr_act_q;
    port_sel_e lat_sel_q;
    logic [D_W-1:0] lat_data_q;

    // Address match against the aligned four-port window and cycle qualification.
    always_comb begin
        hit    = (addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
        io_cyc = !iorq_n && m1_n && hit;
        wr_now = io_cyc && !wr_n;
        rd_now = io_cyc && !rd_n;
    end

    // One read select per port, asserted only during a decoded read.
    genvar gi;
    generate
        for (gi = 0; gi < N_PORT; gi++) begin : g_rsel
            assign rd_sel[gi] = rd_now && (addr[1:0] == gi[1:0]);
        end
    endgenerate

    // Track the write cycle and latch its address and data while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q   <= 1'b0;
            lat_sel_q  <= SEL_MASK;
            lat_data_q <= '0;
        end else begin
            wr_act_q <= wr_now;
            if (wr_now) begin
                lat_sel_q  <= port_sel_e'(addr[1:0]);
                lat_data_q <= din;
            end
        end
    end

    assign wr_commit = wr_act_q && !wr_now;
    assign wr_sel    = lat_sel_q;
    assign wr_data   = lat_data_q;

    // R1: at most one port is selected for reading at a time.
    p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel));

    // R2: a strobe rising edge yields exactly one commit cycle.
    p_commit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

endmodule

// File: rtl/io_reg_bank.sv
// Module: io_reg_bank
// Holds the interrupt mask, the two output registers and the floppy reset bit.
// Loads them from a commit pulse. The floppy bit holds the CPU value, so 0 means
// reset active, which is also its value after chip reset.
module io_reg_bank
    import io_port_pkg::*;
#(
    parameter int D_W = DATA_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_commit,
    input  port_sel_e      wr_sel,
    input  logic [D_W-1:0] wr_data,
    output logic [D_W-1:0] mask_q,
    output logic [D_W-1:0] pb_q,
    output logic [D_W-1:0] pc_q,
    output logic           fdd_q
);

    logic ld_mask, ld_stat, ld_pb, ld_pc;

    // Per-register load strobes from the committed port select.
    always_comb begin
        ld_mask = wr_commit && (wr_sel == SEL_MASK);
        ld_stat = wr_commit && (wr_sel == SEL_STAT);
        ld_pb   = wr_commit && (wr_sel == SEL_PB);
        ld_pc   = wr_commit && (wr_sel == SEL_PC);
    end

    // Interrupt-enable mask, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (ld_mask) mask_q <= wr_data;
    end

    // Relay / Z-motor register, cleared by reset (pins high).
    always_ff @(posedge clk) begin
        if (!rst_n)     pb_q <= '0;
        else if (ld_pb) pb_q <= wr_data;
    end

    // X/Y-motor register, cleared by reset (pins high).
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (ld_pc) pc_q <= wr_data;
    end

    // Floppy reset control: cleared (reset active) by chip reset, released only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       fdd_q <= 1'b0;
        else if (ld_stat) fdd_q <= wr_data[FDD_CTRL_BIT];
    end

    // R7: a relay-port commit lands the latched byte in the register.
    p_pb_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pb |=> (pb_q == $past(wr_data)));

    // R5: the floppy bit moves only on a commit to the status port.
    p_fdd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_stat |=> $stable(fdd_q));

    // R3: the mask keeps its value without a mask-port commit.
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_mask |=> $stable(mask_q));

endmodule

// File: rtl/io_irq_gen.sv
// Module: io_irq_gen
// Combines source levels with their enable bits into an open-drain request.
// Models the released state as irq_n = 1 with the pull-down enable off.
module io_irq_gen
    import io_port_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic [NS-1:0] src,
    input  logic [NS-1:0] enable,
    output logic          irq_n,
    output logic          irq_oe
);

    logic pend;

    // Any enabled, active source requests an interrupt.
    always_comb begin
        pend   = |(src & enable);
        irq_oe = pend;
        irq_n  = !pend;
    end

endmodule

// File: rtl/io_port_irq_ctrl.sv
// Module: io_port_irq_ctrl (top)
// I/O-mapped register block with four ports: interrupt mask, live status and
// floppy reset, and two active-low output registers. Also drives an open-drain
// interrupt request. Assumes bus strobes synchronous to clk and a base address
// aligned to four.
module io_port_irq_ctrl
    import io_port_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic       iorq_n,
    input  logic       m1_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_oe,
    input  logic       cas_in,
    input  logic       prn_cr,
    input  logic       prn_sw,
    input  logic       fdc_int,
    input  logic       cc_key,
    input  logic       pf_key,
    input  logic       rev_in,
    output logic [7:0] pb_n,
    output logic [7:0] pc_n,
    output logic       fdd_rst_n,
    output logic       irq_n,
    output logic       irq_oe
);

    localparam int PAD_W = DATA_W - N_SRC - 1;

    logic [3:0]        rd_sel;
    logic              wr_commit;
    port_sel_e         wr_sel;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] mask_q, pb_q, pc_q;
    logic              fdd_q;
    logic [N_SRC-1:0]  src;
    logic [DATA_W-1:0] status;

    // Source vector in mask-bit order, and the live status byte.
    always_comb begin
        src    = {rev_in, pf_key, cc_key, fdc_int, prn_sw, prn_cr};
        status = {{PAD_W{1'b0}}, src, cas_in};
    end

    io_bus_decode #(
        .ADDR_W(8), .BASE_ADDR(BASE_ADDR), .D_W(DATA_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
        .rd_sel(rd_sel), .wr_commit(wr_commit), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    io_reg_bank #(.D_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_sel(wr_sel),
        .wr_data(wr_data), .mask_q(mask_q), .pb_q(pb_q), .pc_q(pc_q), .fdd_q(fdd_q)
    );

    io_irq_gen #(.NS(N_SRC)) u_irq (
        .src(src), .enable(mask_q[N_SRC-1:0]), .irq_n(irq_n), .irq_oe(irq_oe)
    );

    // Read-data multiplexer driven by the one-hot selects; zero when idle.
    always_comb begin
        dout = '0;
        if (rd_sel[SEL_MASK]) dout = mask_q;
        if (rd_sel[SEL_STAT]) dout = status;
        if (rd_sel[SEL_PB])   dout = pb_q;
        if (rd_sel[SEL_PC])   dout = pc_q;
        dout_oe = |rd_sel;
    end

    // Output pins are the inverse of the stored bytes; the floppy bit passes straight.
    always_comb begin
        pb_n      = ~pb_q;
        pc_n      = ~pc_q;
        fdd_rst_n = fdd_q;
    end

    // R10: data is driven only with the read, I/O and non-fetch strobes in place.
    p_oe_needs_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!rd_n && !iorq_n && m1_n));

    // R1: an opcode-fetch cycle never enables the data bus.
    p_no_fetch_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !m1_n |-> !dout_oe);

endmodule

// File: tb/sim_io_port_irq_ctrl.sv
`timescale 1ns/1ps
// Bench: a behavioural model tracks the registers and is compared with every
// output on each clock. Directed sequences cover each requirement.
module sim_io_port_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic       cas_in = 1'b0;
    logic [5:0] src_in = 6'h00;   // bit i = source i, same order as the mask
    logic [7:0] pb_n, pc_n;
    logic       fdd_rst_n, irq_n, irq_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    io_port_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
        .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout), .dout_oe(dout_oe),
        .cas_in(cas_in), .prn_cr(src_in[0]), .prn_sw(src_in[1]), .fdc_int(src_in[2]),
        .cc_key(src_in[3]), .pf_key(src_in[4]), .rev_in(src_in[5]),
        .pb_n(pb_n), .pc_n(pc_n), .fdd_rst_n(fdd_rst_n), .irq_n(irq_n), .irq_oe(irq_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] m_mask = 8'h00, m_pb = 8'h00, m_pc = 8'h00;
    logic       m_fdd = 1'b0;
    bit         pend_w = 0;
    logic [7:0] pend_a = 8'h00, pend_d = 8'h00;

    always @(posedge clk) begin : model
        bit busy;
        busy = !iorq_n && m1_n && !wr_n && (addr >= 8'h80) && (addr <= 8'h83);
        if (!rst_n) begin
            m_mask = 8'h00; m_pb = 8'h00; m_pc = 8'h00; m_fdd = 1'b0; pend_w = 0;
        end else begin
            if (pend_w && !busy) begin
                case (pend_a)
                    8'h80: m_mask = pend_d;
                    8'h81: m_fdd  = pend_d[0];
                    8'h82: m_pb   = pend_d;
                    8'h83: m_pc   = pend_d;
                    default: ;
                endcase
            end
            pend_w = busy;
            if (busy) begin pend_a = addr; pend_d = din; end
        end
    end

    // Per-cycle comparison, 1 ns after the edge.
    always @(posedge clk) begin : compare
        logic       rd_ok, ip;
        logic [7:0] ed;
        #1;
        if (!done) begin
            rd_ok = !iorq_n && m1_n && !rd_n && (addr >= 8'h80) && (addr <= 8'h83);
            case (addr)
                8'h80:   ed = m_mask;
                8'h81:   ed = {1'b0, src_in, cas_in};
                8'h82:   ed = m_pb;
                default: ed = m_pc;
            endcase
            if (!rd_ok) ed = 8'h00;
            ip = |(src_in & m_mask[5:0]);
            chk("R7 pb_n", pb_n, ~m_pb);
            chk("R8 pc_n", pc_n, ~m_pc);
            chk("R5 fdd_rst_n", {7'd0, fdd_rst_n}, {7'd0, m_fdd});
            chk("R9 irq_oe", {7'd0, irq_oe}, {7'd0, ip});
            chk("R9 irq_n", {7'd0, irq_n}, {7'd0, !ip});
            chk("R10 dout_oe", {7'd0, dout_oe}, {7'd0, rd_ok});
            chk("R10/R3/R4 dout", dout, ed);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic m1v);
        @(negedge clk);
        addr = a; din = d; iorq_n = 1'b0; m1_n = m1v; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1; iorq_n = 1'b1; m1_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic m1v, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; iorq_n = 1'b0; m1_n = m1v; rd_n = 1'b0;
        @(posedge clk); #1;
        d = dout; oe = dout_oe;
        @(negedge clk);
        rd_n = 1'b1; iorq_n = 1'b1; m1_n = 1'b1;
    endtask

    // ---------------- directed sequence ----------------
    initial begin : main
        logic [7:0] rv;
        logic       oe;
        src_in = 6'h3F; cas_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state with all sources high
        chk("R6 pb_n reset", pb_n, 8'hFF);
        chk("R6 pc_n reset", pc_n, 8'hFF);
        chk("R6 fdd_rst_n reset", {7'd0, fdd_rst_n}, 8'h00);
        chk("R6 irq_oe reset", {7'd0, irq_oe}, 8'h00);
        src_in = 6'h00; cas_in = 1'b0;

        // R2: no effect while the strobe stays low, then effect after its rise
        @(negedge clk);
        addr = 8'h82; din = 8'hA5; iorq_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 pb_n held during write", pb_n, 8'hFF);
        wr_n = 1'b1; iorq_n = 1'b1;
        @(posedge clk); #1;
        chk("R2 pb_n after strobe rise", pb_n, 8'h5A);
        @(negedge clk);

        // R7 / R8: output registers and readback
        bus_rd(8'h82, 1'b1, rv, oe);
        chk("R7 readback 82", rv, 8'hA5);
        bus_wr(8'h83, 8'h3C, 1'b1);
        chk("R8 pc_n", pc_n, 8'hC3);
        bus_rd(8'h83, 1'b1, rv, oe);
        chk("R8 readback 83", rv, 8'h3C);

        // R5: floppy reset release/assert, upper bits ignored
        bus_wr(8'h81, 8'hFE, 1'b1);
        chk("R5 upper bits ignored", {7'd0, fdd_rst_n}, 8'h00);
        bus_wr(8'h81, 8'h01, 1'b1);
        chk("R5 release", {7'd0, fdd_rst_n}, 8'h01);
        bus_wr(8'h81, 8'hFE, 1'b1);
        chk("R5 assert by 0", {7'd0, fdd_rst_n}, 8'h00);
        bus_wr(8'h81, 8'h01, 1'b1);

        // R4: live status in several patterns
        src_in = 6'h15; cas_in = 1'b1;
        bus_rd(8'h81, 1'b1, rv, oe);
        chk("R4 status 15/1", rv, 8'h2B);
        src_in = 6'h2A; cas_in = 1'b0;
        bus_rd(8'h81, 1'b1, rv, oe);
        chk("R4 status 2A/0", rv, 8'h54);

        // R3: mask store and readback
        src_in = 6'h00;
        bus_wr(8'h80, 8'hC5, 1'b1);
        bus_rd(8'h80, 1'b1, rv, oe);
        chk("R3 mask readback", rv, 8'hC5);

        // R9: each source against a single enable, then masked off
        for (int i = 0; i < 6; i++) begin
            bus_wr(8'h80, 8'h01 << i, 1'b1);
            src_in = 6'h01 << i;
            @(posedge clk); #1;
            chk("R9 enabled source", {7'd0, irq_oe}, 8'h01);
            src_in = ~(6'h01 << i);
            @(posedge clk); #1;
            chk("R9 other sources masked", {7'd0, irq_oe}, 8'h00);
            @(negedge clk);
            src_in = 6'h00;
        end

        // R1: ignored writes (fetch cycle, outside window), checked via readback
        bus_wr(8'h82, 8'h00, 1'b0);
        bus_wr(8'h84, 8'h00, 1'b1);
        bus_wr(8'h7F, 8'h00, 1'b1);
        chk("R1 pb_n unchanged", pb_n, 8'h5A);
        bus_rd(8'h82, 1'b1, rv, oe);
        chk("R1 readback unchanged", rv, 8'hA5);

        // R10: no drive on a fetch-cycle read or an out-of-window read
        bus_rd(8'h80, 1'b0, rv, oe);
        chk("R10 fetch read oe", {7'd0, oe}, 8'h00);
        bus_rd(8'h90, 1'b1, rv, oe);
        chk("R10 outside oe", {7'd0, oe}, 8'h00);
        chk("R10 outside dout", rv, 8'h00);

        // R6: a second reset re-asserts the floppy reset and clears the registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R6 fdd re-asserted", {7'd0, fdd_rst_n}, 8'h00);
        chk("R6 pb_n cleared", pb_n, 8'hFF);
        chk("R6 pc_n cleared", pc_n, 8'hFF);

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule